// File: doc/BRIEF.md
# Forward Probabilistic Confidence Counter

This block estimates confidence for a single value-predictor entry. Each entry keeps a narrow 3-bit saturating counter. The entry's stored level goes into this block, and the block returns the level to write back, together with a flag that says whether the entry's prediction may be used.

On a misprediction the counter is cleared. On a correct outcome, a step upward is not certain. Each step is taken only with a probability that depends on the current level. A 16-bit pseudo-random sequence decides whether the step is taken. This makes a 3-bit counter behave like a much wider one, so a prediction that is used is very likely to be right.

Two probability tables are provided. One is for recovery by squashing at commit. The other, which is less conservative, is for selective reissue. The storage that holds the counters lives outside this block. The block is shared across updates, and only its random source is stateful.

Top module: `fpc_conf_unit`

## Requirements
- R1: `use_pred` is 1 exactly when `cnt_in` equals 7, whatever the other inputs are.
- R2: With `upd_valid`=1 and `upd_correct`=0, `cnt_out` is 0 from every level.
- R3: With `upd_valid`=1, `upd_correct`=1 and `cnt_in`=0, `cnt_out` is always 1.
- R4: With `mode_sel`=0 (squash at commit), a correct update climbs with probability 1/16 from levels 1 to 4, and with probability 1/32 from levels 5 and 6.
- R5: With `mode_sel`=1 (selective reissue), a correct update climbs with probability 1/8 from levels 1 to 4, and with probability 1/16 from levels 5 and 6.
- R6: A climb of probability 1/2^k happens exactly when the low k bits of the current random word are all zero; otherwise `cnt_out` equals `cnt_in`. A climb is always by exactly one level.
- R7: The random word is a right-shifting Galois LFSR with feedback mask 0xB400 (x^16+x^14+x^13+x^11+1). It is loaded with the seed 0xACE1 by reset. It advances one step on each clock edge where `upd_valid` is 1, and the current word (before the step) decides that update.
- R8: With `upd_valid`=1, `upd_correct`=1 and `cnt_in`=7, `cnt_out` stays 7.
- R9: With `upd_valid`=0, `cnt_out` equals `cnt_in` and the random word keeps its value.
- R10: Over one full LFSR period of 65535 correct updates at level 1 in squash mode, exactly 4095 updates climb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the LFSR seed |
| upd_valid | input | 1 | Update strobe for the presented entry |
| upd_correct | input | 1 | 1 = the entry predicted correctly, 0 = mispredicted |
| mode_sel | input | 1 | 0 = squash-at-commit table, 1 = selective-reissue table |
| cnt_in | input | 3 | Current stored confidence level |
| cnt_out | output | 3 | Level to write back |
| use_pred | output | 1 | Prediction of the entry may be used |

## Verification
The bench builds the block with its default parameters: a 3-bit counter and a 16-bit LFSR with seed 0xACE1. At this size one full random period is only 65535 updates. The bench steps through two complete periods. The first cycles through every level, both modes and both outcomes, and compares each result with an arithmetic model of the LFSR and the probability tables. The second holds level 1 in squash mode, so the climb count can be compared with the exact number of words whose low four bits are zero.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic {
        MODE_SQUASH  = 1'b0,
        MODE_REISSUE = 1'b1
    } fpc_mode_e;
endpackage

// File: rtl/fpc_lfsr.sv
module fpc_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] seq;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.seq = {1'b0, st_q.seq[W-1:1]} ^ (st_q.seq[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{seq: SEED};
        else        st_q <= st_d;
    end

    assign word = st_q.seq;

    p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.seq));
    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq != '0);
endmodule

// File: rtl/fpc_prob_sel.sv
module fpc_prob_sel
    import fpc_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int KW       = 5,
    parameter int TOP_FROM = 5,
    parameter int SQ_MID_K = 4,
    parameter int SQ_TOP_K = 5,
    parameter int RI_MID_K = 3,
    parameter int RI_TOP_K = 4
) (
    input  logic [CNT_W-1:0] level,
    input  fpc_mode_e        mode,
    output logic [KW-1:0]    k
);
    localparam logic [CNT_W-1:0] TOP_LVL = CNT_W'(TOP_FROM);

    always_comb begin
        if (level == '0) begin
            k = '0;
        end else if (level >= TOP_LVL) begin
            k = (mode == MODE_REISSUE) ? KW'(RI_TOP_K) : KW'(SQ_TOP_K);
        end else begin
            k = (mode == MODE_REISSUE) ? KW'(RI_MID_K) : KW'(SQ_MID_K);
        end
    end
endmodule

// File: rtl/fpc_step.sv
module fpc_step #(
    parameter int CNT_W  = 3,
    parameter int LFSR_W = 16,
    parameter int KW     = 5
) (
    input  logic [CNT_W-1:0]  level,
    input  logic              valid,
    input  logic              correct,
    input  logic [KW-1:0]     k,
    input  logic [LFSR_W-1:0] rnd,
    output logic [CNT_W-1:0]  nxt
);
    localparam logic [CNT_W-1:0] MAX_LVL = '1;

    logic [LFSR_W-1:0] mask;
    logic              hit;

    for (genvar i = 0; i < LFSR_W; i++) begin : g_mask
        assign mask[i] = (KW'(i) < k);
    end

    assign hit = ((rnd & mask) == '0);

    always_comb begin
        nxt = level;
        if (valid) begin
            if (!correct)              nxt = '0;
            else if (level == MAX_LVL) nxt = MAX_LVL;
            else if (hit)              nxt = level + 1'b1;
        end
    end
endmodule

// File: rtl/fpc_conf_unit.sv
module fpc_conf_unit
    import fpc_pkg::*;
#(
    parameter int                 CNT_W     = 3,
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
    parameter int                 TOP_FROM  = 5,
    parameter int                 SQ_MID_K  = 4,
    parameter int                 SQ_TOP_K  = 5,
    parameter int                 RI_MID_K  = 3,
    parameter int                 RI_TOP_K  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic             upd_correct,
    input  logic             mode_sel,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_out,
    output logic             use_pred
);
    localparam int               KW      = $clog2(LFSR_W + 1);
    localparam logic [CNT_W-1:0] MAX_LVL = '1;

    logic [LFSR_W-1:0] rnd;
    logic [KW-1:0]     k;
    fpc_mode_e         mode;

    assign mode = fpc_mode_e'(mode_sel);

    fpc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(upd_valid), .word(rnd)
    );

    fpc_prob_sel #(
        .CNT_W(CNT_W), .KW(KW), .TOP_FROM(TOP_FROM),
        .SQ_MID_K(SQ_MID_K), .SQ_TOP_K(SQ_TOP_K),
        .RI_MID_K(RI_MID_K), .RI_TOP_K(RI_TOP_K)
    ) u_prob (
        .level(cnt_in), .mode(mode), .k(k)
    );

    fpc_step #(.CNT_W(CNT_W), .LFSR_W(LFSR_W), .KW(KW)) u_step (
        .level(cnt_in), .valid(upd_valid), .correct(upd_correct),
        .k(k), .rnd(rnd), .nxt(cnt_out)
    );

    assign use_pred = (cnt_in == MAX_LVL);

    p_mispredict_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_correct) |-> (cnt_out == '0));
    p_first_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_correct && cnt_in == '0) |-> (cnt_out == CNT_W'(1)));
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_correct) |->
            (cnt_out == cnt_in || cnt_out == cnt_in + 1'b1));
    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_correct && cnt_in == MAX_LVL) |-> (cnt_out == MAX_LVL));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> (cnt_out == cnt_in));
endmodule

// File: tb/fpc_conf_unit_bench.sv
module fpc_conf_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_valid = 1'b0;
    logic       upd_correct = 1'b0;
    logic       mode_sel = 1'b0;
    logic [2:0] cnt_in = 3'd0;
    logic [2:0] cnt_out;
    logic       use_pred;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] model = 16'hACE1;
    int climbs;

    always #10 clk = ~clk;

    fpc_conf_unit u_fpc_conf_unit (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_correct(upd_correct),
        .mode_sel(mode_sel), .cnt_in(cnt_in), .cnt_out(cnt_out), .use_pred(use_pred)
    );

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic int exp_next(input bit v, input bit c, input bit m,
                                    input int l, input logic [15:0] r);
        int k;
        if (!v) return l;
        if (!c) return 0;
        if (l == 7) return 7;
        k = (l == 0) ? 0 : (l >= 5 ? (m ? 4 : 5) : (m ? 3 : 4));
        return ((r & 16'((1 << k) - 1)) == 16'h0) ? l + 1 : l;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input bit v, input bit c, input bit m, input int l, input string force_tag);
        int e;
        string tag;
        @(negedge clk);
        upd_valid = v; upd_correct = c; mode_sel = m; cnt_in = 3'(l);
        #1;
        e = exp_next(v, c, m, l, model);
        if (force_tag != "")  tag = force_tag;
        else if (!v)          tag = "R9";
        else if (!c)          tag = "R2";
        else if (l == 7)      tag = "R8";
        else if (l == 0)      tag = "R3";
        else if (m)           tag = "R5";
        else                  tag = "R4";
        chk(tag, int'(cnt_out), e);
        chk("R1", int'(use_pred), (l == 7) ? 1 : 0);
        if (v && c && int'(cnt_out) == l + 1 && l != 0) climbs++;
        @(posedge clk);
        if (v) model = lfsr_step(model);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // first draw after reset uses the seed 0xACE1: low 3 bits 001 -> no climb
        apply(1, 1, 1, 1, "R7");
        chk("R7", int'(cnt_out), 1);
        // idle cycles: hold, and LFSR must not move (verified by next strobes)
        for (int l = 0; l < 8; l++) apply(0, 1, l[0], l, "");
        for (int l = 0; l < 8; l++) apply(1, 0, l[0], l, "");
        apply(1, 1, 0, 0, "");
        apply(1, 1, 1, 7, "");
        // full period over all combinations, per-strobe model compare (R6, R7)
        for (int i = 0; i < 65535; i++) begin
            apply(1, ((i / 16) % 8) != 0, (i / 8) % 2 == 1, i % 8, (i % 3 == 0) ? "R6" : "");
            if (i % 4096 == 0) apply(0, 1, 0, 3, "R9");
        end
        // full period at level 1 squash mode: exact climb count
        climbs = 0;
        for (int i = 0; i < 65535; i++) apply(1, 1, 0, 1, "R6");
        chk("R10", climbs, 4095);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule